// File: doc/BRIEF.md
# I2C Target Status and Interrupt Flags

This block holds the status word of an I2C target interface. The target bit engine reports events to it as one-cycle strobes: a finished byte, a match on the own address, a stop, a start or repeated start, a lost drive on SDA, an illegal bus sequence, and the sampled acknowledge and R/W bits. From these the block keeps an 8-bit status word, a clock-stretch request and two interrupt lines.

Software reads the word through a simple register bus. Flags are cleared in two ways. Some are write-1-to-clear. Others clear as a side effect of touching the data register or writing the command register. The clock-stretch request is not stored on its own. It follows the two pending interrupt flags, so the bus is released as soon as software services the interrupt.

Top module: `i2c_tgt_status`

## Requirements
- R1: After the asynchronous reset, status_o reads 0x00 and clk_hold_o, data_irq_o and addr_stop_irq_o are 0.
- R2: Status bit 7 (data flag) becomes 1 in the cycle after byte_done_i is high and bus_err_i is low.
- R3: Status bit 6 (address/stop flag) becomes 1 in the cycle after addr_match_i or stop_i is high.
- R4: Bits 7 and 6 both clear after any of these: a read or write of the data register (address 0xD), a write to the command register (address 0x9), or a write to the status register (address 0xB) with a 1 in that bit. A set event in the same cycle wins over the clear.
- R5: Status bit 5 and clk_hold_o are 1 exactly while bit 7 or bit 6 is 1.
- R6: Status bit 4 takes ack_bit_i (0 = ACK, 1 = NACK) in the cycle after ack_valid_i, and holds it otherwise.
- R7: Status bit 3 (collision) sets after coll_i. It clears after start_i or after a status write with bit 3 = 1. coll_i wins over a clear in the same cycle.
- R8: Status bit 2 (bus error) sets after bus_err_i and clears after a status write with bit 2 = 1. bus_err_i wins over the clear.
- R9: Status bit 1 takes addr_rw_i (1 = host read, 0 = host write) in the cycle after addr_match_i.
- R10: Status bit 0 becomes 1 after addr_match_i and 0 after stop_i. If both come in the same cycle, it becomes 1.
- R11: Register writes never change bits 5, 4, 1 and 0 directly. Writing 0 to a write-1-to-clear bit leaves it unchanged.
- R12: data_irq_o equals bit 7 AND dif_en_i. addr_stop_irq_o equals bit 6 AND apif_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_done_i | input | 1 | Byte transfer finished (strobe) |
| addr_match_i | input | 1 | Own address received (strobe) |
| addr_rw_i | input | 1 | R/W bit of the address packet, valid with addr_match_i |
| stop_i | input | 1 | Stop condition seen (strobe) |
| start_i | input | 1 | Start or repeated start seen (strobe) |
| coll_i | input | 1 | Target failed to drive SDA as intended (strobe) |
| bus_err_i | input | 1 | Illegal bus sequence seen (strobe) |
| ack_valid_i | input | 1 | Host acknowledge bit sampled (strobe) |
| ack_bit_i | input | 1 | Sampled acknowledge bit, 1 = NACK |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| dif_en_i | input | 1 | Data interrupt enable |
| apif_en_i | input | 1 | Address/stop interrupt enable |
| status_o | output | 8 | Status word |
| clk_hold_o | output | 1 | Request to hold SCL low |
| data_irq_o | output | 1 | Data interrupt |
| addr_stop_irq_o | output | 1 | Address/stop interrupt |

## Verification
The bench drives sparse random event strobes mixed with random register traffic to all three decoded addresses and to unused ones. This shows whether each flag reacts only to its own sources and whether side-effect clears are tied to the right addresses. Directed sequences then put a set and a clear in the same cycle, address and stop together, and start together with collision, which tests each priority rule. Writes of 0xFF and 0x00 to the status register separate the read-only bits from the write-1-to-clear ones.

// File: rtl/i2c_tgt_status_pkg.sv
package i2c_tgt_status_pkg;
  localparam int STAT_W    = 8;
  localparam int B_DIF     = 7;
  localparam int B_APIF    = 6;
  localparam int B_HOLD    = 5;
  localparam int B_RXACK   = 4;
  localparam int B_COLL    = 3;
  localparam int B_BERR    = 2;
  localparam int B_DIR     = 1;
  localparam int B_AP      = 0;
  // index into the sticky flag bank
  localparam int N_FLAG    = 4;
  localparam int F_DIF     = 0;
  localparam int F_APIF    = 1;
  localparam int F_COLL    = 2;
  localparam int F_BERR    = 3;
endpackage

// File: rtl/i2c_tgt_access_dec.sv
module i2c_tgt_access_dec #(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hB,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h9,
  parameter int          DATA_W    = 8
) (
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              data_acc_o,
  output logic              cmd_wr_o,
  output logic [DATA_W-1:0] w1c_o
);
  always_comb begin
    data_acc_o = (reg_wr_i || reg_rd_i) && (reg_addr_i == DATA_ADDR);
    cmd_wr_o   = reg_wr_i && (reg_addr_i == CMD_ADDR);
    w1c_o      = (reg_wr_i && (reg_addr_i == STAT_ADDR)) ? reg_wdata_i : '0;
  end
endmodule

// File: rtl/i2c_tgt_flag_bank.sv
module i2c_tgt_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set wins
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_bus_info.sv
module i2c_tgt_bus_info (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_valid_i,
  input  logic ack_bit_i,
  input  logic addr_match_i,
  input  logic addr_rw_i,
  input  logic stop_i,
  output logic rxack_o,
  output logic dir_o,
  output logic ap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxack_o <= 1'b0;
      dir_o   <= 1'b0;
      ap_o    <= 1'b0;
    end else begin
      if (ack_valid_i)  rxack_o <= ack_bit_i;
      if (addr_match_i) dir_o   <= addr_rw_i;
      // address outranks a coincident stop
      if (addr_match_i)  ap_o <= 1'b1;
      else if (stop_i)   ap_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
  import i2c_tgt_status_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hB,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic              addr_match_i,
  input  logic              addr_rw_i,
  input  logic              stop_i,
  input  logic              start_i,
  input  logic              coll_i,
  input  logic              bus_err_i,
  input  logic              ack_valid_i,
  input  logic              ack_bit_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              dif_en_i,
  input  logic              apif_en_i,
  output logic [7:0]        status_o,
  output logic              clk_hold_o,
  output logic              data_irq_o,
  output logic              addr_stop_irq_o
);
  logic              data_acc, cmd_wr;
  logic [STAT_W-1:0] w1c;
  logic [N_FLAG-1:0] fl_set, fl_clr, fl_q;
  logic              rxack, dir, ap;
  logic              svc_clr;
  logic              unused_w1c;

  i2c_tgt_access_dec #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .CMD_ADDR (CMD_ADDR),
    .DATA_W   (STAT_W)
  ) u_dec (
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .data_acc_o (data_acc),
    .cmd_wr_o   (cmd_wr),
    .w1c_o      (w1c)
  );

  // read-only positions carry no write effect
  assign unused_w1c = ^{w1c[B_HOLD], w1c[B_RXACK], w1c[B_DIR], w1c[B_AP]};
  assign svc_clr    = data_acc || cmd_wr;

  always_comb begin
    fl_set[F_DIF]  = byte_done_i && !bus_err_i;
    fl_clr[F_DIF]  = svc_clr || w1c[B_DIF];
    fl_set[F_APIF] = addr_match_i || stop_i;
    fl_clr[F_APIF] = svc_clr || w1c[B_APIF];
    fl_set[F_COLL] = coll_i;
    fl_clr[F_COLL] = start_i || w1c[B_COLL];
    fl_set[F_BERR] = bus_err_i;
    fl_clr[F_BERR] = w1c[B_BERR];
  end

  i2c_tgt_flag_bank #(.N(N_FLAG)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .q_o   (fl_q)
  );

  i2c_tgt_bus_info u_info (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_valid_i (ack_valid_i),
    .ack_bit_i   (ack_bit_i),
    .addr_match_i(addr_match_i),
    .addr_rw_i   (addr_rw_i),
    .stop_i      (stop_i),
    .rxack_o     (rxack),
    .dir_o       (dir),
    .ap_o        (ap)
  );

  always_comb begin
    clk_hold_o           = fl_q[F_DIF] || fl_q[F_APIF];
    status_o             = '0;
    status_o[B_DIF]      = fl_q[F_DIF];
    status_o[B_APIF]     = fl_q[F_APIF];
    status_o[B_HOLD]     = clk_hold_o;
    status_o[B_RXACK]    = rxack;
    status_o[B_COLL]     = fl_q[F_COLL];
    status_o[B_BERR]     = fl_q[F_BERR];
    status_o[B_DIR]      = dir;
    status_o[B_AP]       = ap;
    data_irq_o           = fl_q[F_DIF] && dif_en_i;
    addr_stop_irq_o      = fl_q[F_APIF] && apif_en_i;
  end
endmodule

// File: rtl/i2c_tgt_status_chk.sv
module i2c_tgt_status_chk #(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'hD
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_done_i,
  input logic              addr_match_i,
  input logic              addr_rw_i,
  input logic              stop_i,
  input logic              start_i,
  input logic              coll_i,
  input logic              bus_err_i,
  input logic              ack_valid_i,
  input logic              ack_bit_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              dif_en_i,
  input logic [7:0]        status_o,
  input logic              clk_hold_o,
  input logic              data_irq_o
);
  AST_DIF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !bus_err_i) |=> status_o[7]); // R2
  AST_APIF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_match_i || stop_i) |=> status_o[6]); // R3
  AST_DATA_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == DATA_ADDR && !byte_done_i && !addr_match_i && !stop_i)
    |=> (!status_o[7] && !status_o[6])); // R4
  AST_HOLD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !bus_err_i) |=> clk_hold_o); // R5
  AST_RXACK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |=> (status_o[4] == $past(ack_bit_i))); // R6
  AST_COLL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !coll_i) |=> !status_o[3]); // R7
  AST_BERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> status_o[2]); // R8
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i |=> (status_o[1] == $past(addr_rw_i))); // R9
  AST_AP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !addr_match_i) |=> !status_o[0]); // R10
  AST_RO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_valid_i && !addr_match_i && !stop_i) |=> $stable({status_o[4], status_o[1], status_o[0]})); // R11
  AST_DATA_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_irq_o |-> (status_o[7] && dif_en_i)); // R12
endmodule

bind i2c_tgt_status i2c_tgt_status_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_done_i (byte_done_i),
  .addr_match_i(addr_match_i),
  .addr_rw_i   (addr_rw_i),
  .stop_i      (stop_i),
  .start_i     (start_i),
  .coll_i      (coll_i),
  .bus_err_i   (bus_err_i),
  .ack_valid_i (ack_valid_i),
  .ack_bit_i   (ack_bit_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .dif_en_i    (dif_en_i),
  .status_o    (status_o),
  .clk_hold_o  (clk_hold_o),
  .data_irq_o  (data_irq_o)
);

// File: tb/i2c_tgt_status_test.sv
module i2c_tgt_status_test;
  localparam logic [3:0] A_STAT = 4'hB, A_DATA = 4'hD, A_CMD = 4'h9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bd, am, rw, sp, st, co, be, av, ab, wr, rd, de, ae;
  logic [3:0] ad;
  logic [7:0] wd;
  logic [7:0] status_o;
  logic clk_hold_o, data_irq_o, addr_stop_irq_o;
  logic [7:0] exp_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_tgt_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_done_i(bd), .addr_match_i(am), .addr_rw_i(rw),
    .stop_i(sp), .start_i(st), .coll_i(co), .bus_err_i(be), .ack_valid_i(av), .ack_bit_i(ab),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(ad), .reg_wdata_i(wd),
    .dif_en_i(de), .apif_en_i(ae), .status_o(status_o), .clk_hold_o(clk_hold_o),
    .data_irq_o(data_irq_o), .addr_stop_irq_o(addr_stop_irq_o));

  // next status word from the requirements, using current bench inputs
  function automatic logic [7:0] model(logic [7:0] s);
    logic [7:0] n = s;
    logic svc = ((rd || wr) && ad == A_DATA) || (wr && ad == A_CMD);
    logic [7:0] w = (wr && ad == A_STAT) ? wd : 8'h00;
    if (bd && !be) n[7] = 1'b1; else if (svc || w[7]) n[7] = 1'b0;
    if (am || sp) n[6] = 1'b1; else if (svc || w[6]) n[6] = 1'b0;
    if (av) n[4] = ab;
    if (co) n[3] = 1'b1; else if (st || w[3]) n[3] = 1'b0;
    if (be) n[2] = 1'b1; else if (w[2]) n[2] = 1'b0;
    if (am) n[1] = rw;
    if (am) n[0] = 1'b1; else if (sp) n[0] = 1'b0;
    n[5] = n[7] | n[6];
    return n;
  endfunction

  task automatic expect_eq(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    expect_eq("R2 data flag",      status_o[7], exp_s[7]);
    expect_eq("R3 addr/stop flag", status_o[6], exp_s[6]);
    expect_eq("R5 hold bit",       status_o[5], exp_s[5]);
    expect_eq("R5 clk_hold_o",     clk_hold_o,  exp_s[5]);
    expect_eq("R6 rxack",          status_o[4], exp_s[4]);
    expect_eq("R7 collision",      status_o[3], exp_s[3]);
    expect_eq("R8 bus error",      status_o[2], exp_s[2]);
    expect_eq("R9 direction",      status_o[1], exp_s[1]);
    expect_eq("R10 addr-or-stop",  status_o[0], exp_s[0]);
    expect_eq("R12 data irq",      data_irq_o,      exp_s[7] & de);
    expect_eq("R12 addr/stop irq", addr_stop_irq_o, exp_s[6] & ae);
  endtask

  task automatic idle();
    {bd, am, rw, sp, st, co, be, av, ab, wr, rd} = '0;
    ad = 4'h0; wd = 8'h00;
  endtask

  // inputs are set at a falling edge; one rising edge; compare at the next falling edge
  task automatic step();
    logic [7:0] nx = model(exp_s);
    @(posedge clk);
    @(negedge clk);
    exp_s = nx;
    compare_all();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); de = 1'b1; ae = 1'b1;
    exp_s = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq("R1 reset status", status_o, 8'h00);
    expect_eq("R1 reset hold/irq", {clk_hold_o, data_irq_o, addr_stop_irq_o}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bd = ($urandom % 6) == 0;  am = ($urandom % 8) == 0;
      rw = $urandom;             sp = ($urandom % 10) == 0;
      st = ($urandom % 10) == 0; co = ($urandom % 12) == 0;
      be = ($urandom % 14) == 0; av = ($urandom % 5) == 0;
      ab = $urandom;
      de = $urandom;             ae = $urandom;
      case ($urandom % 8)
        0: begin wr = 1'b1; ad = A_STAT; end
        1: begin wr = 1'b1; ad = A_DATA; end
        2: begin rd = 1'b1; ad = A_DATA; end
        3: begin wr = 1'b1; ad = A_CMD;  end
        4: begin wr = 1'b1; ad = 4'($urandom); end
        5: begin rd = 1'b1; ad = 4'($urandom); end
        default: ;
      endcase
      wd = 8'($urandom);
      step();
    end

    // directed corners
    de = 1'b1; ae = 1'b1;
    bd = 1; step();
    rd = 1; ad = A_DATA; step();
    expect_eq("R4 data read clears flag 7", status_o[7], 1'b0);
    expect_eq("R5 hold released after service", clk_hold_o, 1'b0);
    bd = 1; step();
    bd = 1; wr = 1; ad = A_DATA; step();
    expect_eq("R4 set wins over data access", status_o[7], 1'b1);
    am = 1; rw = 1; wr = 1; ad = A_CMD; step();
    expect_eq("R4 address set wins over command write", status_o[6], 1'b1);
    wr = 1; ad = A_CMD; step();
    expect_eq("R4 command write clears flags", status_o[7:6], 2'b00);
    am = 1; sp = 1; rw = 0; step();
    expect_eq("R10 address wins over stop", status_o[0], 1'b1);
    expect_eq("R9 direction write", status_o[1], 1'b0);
    wr = 1; ad = A_STAT; wd = 8'h40; step();
    expect_eq("R4 w1c clears bit 6", status_o[6], 1'b0);
    sp = 1; step();
    expect_eq("R10 stop source", status_o[0], 1'b0);
    co = 1; be = 1; step();
    co = 1; st = 1; step();
    expect_eq("R7 coll wins over start", status_o[3], 1'b1);
    st = 1; step();
    expect_eq("R7 start clears collision", status_o[3], 1'b0);
    co = 1; step();
    wr = 1; ad = A_STAT; wd = 8'h00; step();
    expect_eq("R11 write 0 keeps w1c bits", status_o[3:2], 2'b11);
    av = 1; ab = 1; am = 1; rw = 1; step();
    wr = 1; ad = A_STAT; wd = 8'hFF; step();
    expect_eq("R11 read-only bits unchanged", {status_o[4], status_o[1], status_o[0]}, 3'b111);
    expect_eq("R8 w1c clears bus error", status_o[2], 1'b0);
    expect_eq("R7 w1c clears collision", status_o[3], 1'b0);
    be = 1; wr = 1; ad = A_STAT; wd = 8'h04; step();
    expect_eq("R8 bus error set wins", status_o[2], 1'b1);
    bd = 1; be = 1; wr = 1; ad = A_CMD; step();
    expect_eq("R2 no data flag with bus error", status_o[7], 1'b0);
    av = 1; ab = 0; step();
    expect_eq("R6 ACK recorded", status_o[4], 1'b0);
    bd = 1; de = 0; step();
    expect_eq("R12 data irq masked", data_irq_o, 1'b0);
    de = 1; #1;
    expect_eq("R12 data irq enabled", data_irq_o, 1'b1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule